// File: doc/BRIEF.md
# JTAG Data-Register Load Sequencer

This engine drives the three output pins of a JTAG port so that a parallel word ends up in the data register of a target device. It always begins and ends with the target's TAP in Run-Test/Idle. A one-cycle start strobe captures the word and the number of valid bits it carries. The engine then plays a fixed pattern, one TCK period per step: it walks into Shift-DR, sends the word most significant bit first, then exits through two steps that repeat the last bit and update the register, and finally returns to idle.

TCK is made by dividing the system clock by `CLK_DIV`. TMS and TDI only change on the falling edge of TCK, so the target sees them stable on every rising edge. The caller's word is right-aligned: bit `len-1` goes out first and bit 0 goes out last, whatever bit numbering the caller used to assemble it. After the last step a one-clock done pulse marks completion. The block is meant to sit under a debug or boundary-scan controller that issues repeated register loads.

Top module: `jtag_dr_loader`

## Requirements
- R1: After reset and whenever the engine is idle, busy_o, done_o, tck_o, tms_o and tdi_o are all 0.
- R2: A start_i pulse while idle with 1 <= len_i <= DATA_W makes busy_o 1 on the next clock. From then on tck_o has a period of CLK_DIV system clocks and stays high for CLK_DIV/2 of them.
- R3: At the first TCK rising edge of a load, TMS=1 and TDI=0. At the second and third rising edges, TMS=0 and TDI=0.
- R4: The next len-1 rising edges carry TMS=0, with TDI equal to data bit len-1, then len-2, and so on down to bit 1.
- R5: The next two rising edges carry TMS=1 and TDI equal to data bit 0. One more rising edge follows with TMS=0 and TDI still equal to bit 0. A load therefore has exactly len+5 rising edges.
- R6: With len_i = 1 there are no shift edges. Bit 0 appears first at the fourth rising edge, and the load has 6 rising edges in total.
- R7: Data bits at index len_i and above have no effect on TDI.
- R8: TMS and TDI do not change while tck_o is high.
- R9: done_o is high for exactly one system clock per load. That clock is the first one in which busy_o is back at 0, and busy_o only falls together with done_o.
- R10: A start_i pulse while busy_o is 1 is ignored. The load in progress keeps its own data and length.
- R11: A start_i pulse with len_i = 0 or len_i > DATA_W is ignored, and the engine stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-clock request to begin a load |
| data_i | input | DATA_W | Word to shift, right-aligned |
| len_i | input | LEN_W | Number of valid bits, 1 to DATA_W |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-clock pulse when a load completes |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG serial data toward the target |

## Verification
- **Phase counter errors.** A step counter that is off by one in any phase changes the number of TCK rising edges. It also moves the point where TMS goes high, so the error shows within one TCK period of the faulty phase and in the total edge count.
- **Shift register errors.** A wrong alignment or shift direction puts the wrong value on TDI. This shows at the very first shift edge, or at the exit edges when only bit 0 is affected.
- **Divider and handshake errors.** Divider mistakes show as a wrong gap between rising edges, or a wrong high time, on the first TCK period. Handshake faults, such as restarting on a busy start or accepting a bad length, show within a few clocks on busy_o or on TCK activity.

// File: rtl/jtag_ld_pkg.sv
package jtag_ld_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ENTER = 3'd1,
    PH_PAD   = 3'd2,
    PH_SHIFT = 3'd3,
    PH_EXIT  = 3'd4,
    PH_BACK  = 3'd5
  } phase_e;
endpackage

// File: rtl/jtag_ld_tck_gen.sv
module jtag_ld_tck_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tck_o,
  output logic step_end_o
);
  localparam int unsigned HI_CYC = CLK_DIV / 2;
  localparam int unsigned LO_CYC = CLK_DIV - HI_CYC;
  localparam int unsigned CNT_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_RISE = CNT_W'(LO_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tck_q;

  assign step_end_o = run_i && (cnt_q == CNT_LAST);
  assign tck_o      = tck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (run_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        tck_q <= 1'b0;   // falling edge: step boundary
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_RISE) tck_q <= 1'b1;
      end
    end else begin
      tck_q <= 1'b0;
    end
  end
endmodule

// File: rtl/jtag_ld_seq.sv
module jtag_ld_seq
  import jtag_ld_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_end_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             busy_o,
  output logic             done_o,
  output phase_e           phase_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);
  localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO     = LEN_W'(2);

  phase_e           phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q;
  logic             len_ok;

  assign len_ok  = (len_i != '0) && (len_i <= LEN_MAX);
  assign load_o  = start_i && (phase_q == PH_IDLE) && len_ok;
  assign shift_o = step_end_i && (phase_q == PH_SHIFT);
  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = done_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        phase_q <= PH_ENTER;
        cnt_q   <= '0;
        len_q   <= len_i;
      end else if (step_end_i) begin
        unique case (phase_q)
          PH_ENTER: begin
            phase_q <= PH_PAD;
            cnt_q   <= '0;
          end
          PH_PAD: begin
            if (cnt_q == ONE) begin
              cnt_q   <= '0;
              phase_q <= (len_q == ONE) ? PH_EXIT : PH_SHIFT;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
          PH_SHIFT: begin
            if (cnt_q == len_q - TWO) begin
              cnt_q   <= '0;
              phase_q <= PH_EXIT;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
          PH_EXIT: begin
            if (cnt_q == ONE) begin
              cnt_q   <= '0;
              phase_q <= PH_BACK;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
          PH_BACK: begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/jtag_ld_shreg.sv
module jtag_ld_shreg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              shift_i,
  output logic              msb_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [LEN_W-1:0]  pad;

  // left-justify so the first bit to send sits at the top
  assign pad   = LEN_MAX - len_i;
  assign msb_o = sh_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= data_i << pad;
    else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end
endmodule

// File: rtl/jtag_dr_loader.sv
module jtag_dr_loader
  import jtag_ld_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o
);
  logic   load, shift, step_end, msb;
  phase_e phase;

  jtag_ld_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .len_i      (len_i),
    .step_end_i (step_end),
    .load_o     (load),
    .shift_o    (shift),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .phase_o    (phase)
  );

  jtag_ld_tck_gen #(.CLK_DIV(CLK_DIV)) u_tck (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (load),
    .run_i      (busy_o),
    .tck_o      (tck_o),
    .step_end_o (step_end)
  );

  jtag_ld_shreg #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_sh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  (data_i),
    .len_i   (len_i),
    .shift_i (shift),
    .msb_o   (msb)
  );

  assign tms_o = (phase == PH_ENTER) || (phase == PH_EXIT);
  assign tdi_o = ((phase == PH_SHIFT) || (phase == PH_EXIT) || (phase == PH_BACK)) && msb;
endmodule

// File: rtl/jtag_dr_loader_chk.sv
module jtag_dr_loader_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] data_i,
  input logic [LEN_W-1:0]  len_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              tck_o,
  input logic              tms_o,
  input logic              tdi_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tck_o && !tms_o && !tdi_o));

  a_r2_tck_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |-> busy_o);

  a_r8_hold_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o)));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r9_end_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  a_r11_bad_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && ((len_i == '0) || (len_i > LEN_W'(DATA_W)))) |=> !busy_o);
endmodule

bind jtag_dr_loader jtag_dr_loader_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/jtag_dr_loader_tb.sv
module jtag_dr_loader_tb;
  localparam int DATA_W  = 32;
  localparam int CLK_DIV = 4;
  localparam int LEN_W   = $clog2(DATA_W + 1);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic [LEN_W-1:0]  len_i = '0;
  logic busy_o, done_o, tck_o, tms_o, tdi_o;

  int n_chk = 0, n_fail = 0;

  jtag_dr_loader #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_dut (.*);

  always #5 clk_i = ~clk_i;

  // port monitor, sampled on the falling system clock
  logic mon_clr = 1'b0;
  logic e_tms [0:63];
  logic e_tdi [0:63];
  int   n_edges, gap_bad, hi_bad, hold_bad, done_cnt, done_busy_bad;
  int   cyc = 0, last_rise, hi_run;
  logic tck_prev = 1'b0, tms_hold, tdi_hold;

  always @(negedge clk_i) begin
    cyc++;
    if (mon_clr) begin
      n_edges = 0; gap_bad = 0; hi_bad = 0; hold_bad = 0;
      done_cnt = 0; done_busy_bad = 0; hi_run = 0;
    end
    if (tck_o && !tck_prev) begin
      if (n_edges < 64) begin
        e_tms[n_edges] = tms_o;
        e_tdi[n_edges] = tdi_o;
      end
      if (n_edges > 0 && (cyc - last_rise) != CLK_DIV) gap_bad++;
      last_rise = cyc;
      n_edges++;
      tms_hold = tms_o;
      tdi_hold = tdi_o;
      hi_run = 1;
    end else if (tck_o && tck_prev) begin
      hi_run++;
      if (tms_o !== tms_hold || tdi_o !== tdi_hold) hold_bad++;
    end else if (!tck_o && tck_prev) begin
      if (hi_run != CLK_DIV / 2) hi_bad++;
    end
    if (done_o) begin
      done_cnt++;
      if (busy_o) done_busy_bad++;
    end
    tck_prev = tck_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_tms(int k, int len);
    if (k == 0) return 1'b1;
    if (k <= len + 1) return 1'b0;
    if (k <= len + 3) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic exp_tdi(int k, logic [DATA_W-1:0] d, int len);
    if (k < 3) return 1'b0;
    if (k <= len + 1) return d[len + 2 - k];
    return d[0];
  endfunction

  task automatic clear_mon();
    @(posedge clk_i);
    mon_clr = 1'b1;
    @(negedge clk_i);
    #1 mon_clr = 1'b0;
  endtask

  task automatic run_load(input logic [DATA_W-1:0] d, input int len,
                          input bit poke, input string tag);
    int t;
    clear_mon();
    @(negedge clk_i);
    start_i = 1'b1; data_i = d; len_i = LEN_W'(len);
    @(negedge clk_i);
    start_i = 1'b0;
    #1 chk(busy_o === 1'b1, "R2", {tag, " busy after start"}, busy_o, 1);
    if (poke) begin  // R10: restart attempt mid-load
      repeat (3 * CLK_DIV + 1) @(negedge clk_i);
      start_i = 1'b1; data_i = ~d; len_i = LEN_W'(DATA_W);
      @(negedge clk_i);
      start_i = 1'b0;
    end
    t = 0;
    while (!done_o && t < 4000) begin
      @(negedge clk_i); #1; t++;
    end
    repeat (3) @(negedge clk_i);
    #1;
    chk(done_cnt == 1, "R9", {tag, " done pulses"}, done_cnt, 1);
    chk(done_busy_bad == 0, "R9", {tag, " done with busy"}, done_busy_bad, 0);
    chk(n_edges == len + 5, poke ? "R10" : (len == 1 ? "R6" : "R5"),
        {tag, " rising edge count"}, n_edges, len + 5);
    chk(gap_bad == 0 && hi_bad == 0, "R2", {tag, " tck period/high time"},
        gap_bad + hi_bad, 0);
    chk(hold_bad == 0, "R8", {tag, " tms/tdi moved while tck high"}, hold_bad, 0);
    chk(!busy_o && !tck_o && !tms_o && !tdi_o, "R1", {tag, " idle after load"},
        {busy_o, tck_o, tms_o, tdi_o}, 0);
    for (int k = 0; k < len + 5 && k < n_edges && k < 64; k++) begin
      string req;
      req = poke ? "R10" : (k < 3) ? "R3" : (k <= len + 1) ? "R4" : (len == 1 ? "R6" : "R5");
      chk(e_tms[k] === exp_tms(k, len), req, $sformatf("%s edge %0d tms", tag, k),
          e_tms[k], exp_tms(k, len));
      chk(e_tdi[k] === exp_tdi(k, d, len), req, $sformatf("%s edge %0d tdi", tag, k),
          e_tdi[k], exp_tdi(k, d, len));
    end
  endtask

  task automatic bad_len(input int len);
    clear_mon();
    @(negedge clk_i);
    start_i = 1'b1; data_i = '1; len_i = LEN_W'(len);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4 * CLK_DIV) @(negedge clk_i);
    #1;
    chk(!busy_o && n_edges == 0, "R11", $sformatf("len %0d rejected", len),
        busy_o + n_edges, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    #1 chk(!busy_o && !done_o && !tck_o && !tms_o && !tdi_o, "R1", "in reset",
           {busy_o, done_o, tck_o, tms_o, tdi_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    #1 chk(!busy_o && !done_o && !tck_o && !tms_o && !tdi_o, "R1", "after reset",
           {busy_o, done_o, tck_o, tms_o, tdi_o}, 0);

    run_load(32'h0000_0005, 3, 1'b0, "short");
    run_load(32'h0000_0001, 1, 1'b0, "len1_one");
    run_load(32'hFFFF_FFFE, 1, 1'b0, "len1_R7_upper");
    run_load(32'h8000_0001, DATA_W, 1'b0, "full");
    run_load(32'hA5A5_A5A5, 2, 1'b0, "len2_R7_upper");
    run_load(32'h0000_CAFE, 16, 1'b1, "busy_poke");
    bad_len(0);
    bad_len(DATA_W + 1);
    bad_len((1 << LEN_W) - 1);

    for (int i = 0; i < 30; i++) begin
      logic [DATA_W-1:0] d;
      int len;
      d = $urandom;
      len = 1 + ($urandom % DATA_W);
      run_load(d, len, (i % 7) == 3, $sformatf("rand%0d", i));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule